// File: doc/BRIEF.md
# Loop Trip Predictor

This block predicts the direction of loop-closing branches, the ones that go taken a fixed number of times and then fall through once. It holds a small table addressed by a slice of the branch address. Each slot holds two counters. One is the trip length learned on the last exit. The other counts the taken outcomes seen since that exit. A fetch stage presents a PC on the lookup side and gets a taken/not-taken guess in the same cycle. The execute stage reports each resolved branch on the update side, and the slot it addresses is advanced at the next clock edge.

A slot that has never seen an exit holds the largest possible trip length, so it guesses taken on the first pass through a loop. When the loop first falls through, the slot records how many taken outcomes came before that exit. On later passes it guesses taken until the live counter reaches that length, and guesses not taken on the exit iteration.

Top module: `loop_trip_predictor`

## Requirements
- R1: After a synchronous active-low reset every slot holds a learned length of all ones (2^CNT_W-1) and a live count of zero, so every lookup address predicts taken.
- R2: `lk_taken` is combinational from `lk_pc`. It is 1 exactly when the addressed slot's live count is strictly below its learned length.
- R3: A valid update with `upd_taken`=1 raises the addressed slot's live count by one, and the new value is visible to lookups from the following cycle.
- R4: A valid update with `upd_taken`=0 copies the live count into the learned length and clears the live count, both at the same clock edge.
- R5: Once a slot has seen one exit after N taken outcomes, it predicts N taken results followed by one not-taken result on every later pass of that loop.
- R6: The live count stops at 2^CNT_W-1 and does not wrap. An untrained slot that has seen that many taken outcomes predicts not taken and keeps doing so through further taken updates.
- R7: The slot number is PC bits [PC_LSB+IDX_W-1:PC_LSB] (bits [5:2] by default). Addresses that differ only outside that field share a slot, and an update leaves every other slot unchanged.
- R8: When `upd_valid` is 0, `upd_pc` and `upd_taken` have no effect on any slot.
- R9: A lookup of the slot being updated in the same cycle returns the prediction from the state before that update.
- R10: An exit reported with a live count of zero sets the learned length to zero. That slot then predicts not taken, even after further taken updates.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_pc | input | PC_W | Fetch address to predict |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| upd_valid | input | 1 | A resolved branch is presented |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction, 1 = taken |

## Verification
A corrupted counter in a slot is not visible at the ports until that slot is looked up. It then shows as the exit guess moving to the wrong iteration: one pass early or late if the live count is off, or on every later pass if the learned length is wrong. A counter that wraps instead of saturating shows as taken returning after 2^CNT_W taken updates on an untrained slot. The bench therefore checks the prediction at each iteration boundary, directly after each update edge, across several passes.

// File: rtl/lp_pkg.sv
// Shared types for the loop trip predictor.
// Assumes: one update per cycle at most.
package lp_pkg;
    // Action applied to one slot on a clock edge.
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_STEP  = 2'd1,
        ACT_CLOSE = 2'd2
    } lp_act_e;
endpackage

// File: rtl/lp_index.sv
// Maps a byte address to a table slot number.
// Assumes: PC_LSB + IDX_W <= PC_W; bits below PC_LSB are instruction offset.
module lp_index #(
    parameter int PC_W   = 32,
    parameter int IDX_W  = 4,
    parameter int PC_LSB = 2
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx
);
    // Select the slot field just above the offset bits.
    assign idx = IDX_W'(pc >> PC_LSB);
endmodule

// File: rtl/lp_slot.sv
// One table slot: learned trip length and live iteration count.
// Assumes: the action input is already decoded for this slot only.
module lp_slot
    import lp_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  lp_act_e          act,
    output logic [CNT_W-1:0] prev_q,
    output logic [CNT_W-1:0] cur_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Count state: reset to untrained, step on taken, close on exit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= CNT_MAX;
            cur_q  <= '0;
        end else begin
            case (act)
                ACT_STEP: begin
                    if (cur_q != CNT_MAX) cur_q <= cur_q + 1'b1;
                end
                ACT_CLOSE: begin
                    prev_q <= cur_q;
                    cur_q  <= '0;
                end
                default: ;
            endcase
        end
    end

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (prev_q == CNT_MAX && cur_q == '0)); // R1
    AST_STEP_ADDS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_STEP && cur_q != CNT_MAX) |=> (cur_q == $past(cur_q) + 1'b1)); // R3
    AST_CLOSE_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_CLOSE) |=> (prev_q == $past(cur_q) && cur_q == '0)); // R4
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_STEP && cur_q == CNT_MAX) |=> (cur_q == CNT_MAX)); // R6
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_HOLD) |=> ($stable(cur_q) && $stable(prev_q))); // R8
endmodule

// File: rtl/lp_compare.sv
// Turns a slot's two counts into a direction guess.
// Assumes: both counts are the same width and unsigned.
module lp_compare #(
    parameter int CNT_W = 4
) (
    input  logic [CNT_W-1:0] cur,
    input  logic [CNT_W-1:0] prev,
    output logic             taken
);
    // Taken while the loop has not yet reached its learned length.
    assign taken = (cur < prev);
endmodule

// File: rtl/loop_trip_predictor.sv
// Loop trip predictor top: slot table, update decode, lookup read.
// Assumes: at most one update per cycle; lookups see pre-edge state.
module loop_trip_predictor
    import lp_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int IDX_W  = 4,
    parameter int CNT_W  = 4,
    parameter int PC_LSB = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_taken,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken
);
    localparam int DEPTH = 1 << IDX_W;

    logic [IDX_W-1:0] lk_idx;
    logic [IDX_W-1:0] upd_idx;
    logic [CNT_W-1:0] prev_tbl [DEPTH];
    logic [CNT_W-1:0] cur_tbl  [DEPTH];
    logic [CNT_W-1:0] lk_prev;
    logic [CNT_W-1:0] lk_cur;

    lp_index #(.PC_W(PC_W), .IDX_W(IDX_W), .PC_LSB(PC_LSB)) u_lk_index (
        .pc  (lk_pc),
        .idx (lk_idx)
    );

    lp_index #(.PC_W(PC_W), .IDX_W(IDX_W), .PC_LSB(PC_LSB)) u_upd_index (
        .pc  (upd_pc),
        .idx (upd_idx)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        lp_act_e act_w;

        // Decode the update into this slot's action.
        always_comb begin
            act_w = ACT_HOLD;
            if (upd_valid && upd_idx == IDX_W'(i))
                act_w = upd_taken ? ACT_STEP : ACT_CLOSE;
        end

        lp_slot #(.CNT_W(CNT_W)) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .act    (act_w),
            .prev_q (prev_tbl[i]),
            .cur_q  (cur_tbl[i])
        );
    end

    // Read the addressed slot for the lookup.
    always_comb begin
        lk_prev = prev_tbl[lk_idx];
        lk_cur  = cur_tbl[lk_idx];
    end

    lp_compare #(.CNT_W(CNT_W)) u_compare (
        .cur   (lk_cur),
        .prev  (lk_prev),
        .taken (lk_taken)
    );
endmodule

// File: tb/loop_trip_predictor_tb.sv
module loop_trip_predictor_tb;
    localparam int PC_W = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] lk_pc = '0;
    logic            lk_taken;
    logic            upd_valid = 1'b0;
    logic [PC_W-1:0] upd_pc = '0;
    logic            upd_taken = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    loop_trip_predictor u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_pc     (lk_pc),
        .lk_taken  (lk_taken),
        .upd_valid (upd_valid),
        .upd_pc    (upd_pc),
        .upd_taken (upd_taken)
    );

    function automatic logic [PC_W-1:0] pc_of(input int slot);
        return PC_W'(slot) << 2;
    endfunction

    task automatic check(input logic [PC_W-1:0] pc, input logic exp, input string req);
        lk_pc = pc;
        #1;
        n_chk++;
        if (lk_taken !== exp) begin
            n_bad++;
            $display("FAIL %s pc=%h actual=%b expected=%b", req, pc, lk_taken, exp);
        end
    endtask

    task automatic upd(input logic [PC_W-1:0] pc, input logic tk);
        @(negedge clk);
        upd_valid = 1'b1;
        upd_pc    = pc;
        upd_taken = tk;
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    task automatic t_reset();
        for (int s = 0; s < 16; s++) check(pc_of(s), 1'b1, "R1");
    endtask

    task automatic t_train();
        // first pass: 3 taken then exit, all guessed taken
        for (int k = 0; k < 3; k++) begin
            check(pc_of(1), 1'b1, "R3");
            upd(pc_of(1), 1'b1);
        end
        check(pc_of(1), 1'b1, "R2");
        upd(pc_of(1), 1'b0);
        // two trained passes
        for (int p = 0; p < 2; p++) begin
            for (int k = 0; k < 3; k++) begin
                check(pc_of(1), 1'b1, "R5");
                upd(pc_of(1), 1'b1);
            end
            check(pc_of(1), 1'b0, "R5");
            upd(pc_of(1), 1'b0);
        end
        check(pc_of(1), 1'b1, "R4");
    endtask

    task automatic t_zero();
        upd(pc_of(2), 1'b0);
        check(pc_of(2), 1'b0, "R10");
        upd(pc_of(2), 1'b1);
        check(pc_of(2), 1'b0, "R10");
    endtask

    task automatic t_sat();
        for (int k = 0; k < 14; k++) upd(pc_of(3), 1'b1);
        check(pc_of(3), 1'b1, "R6");
        upd(pc_of(3), 1'b1);
        check(pc_of(3), 1'b0, "R6");
        upd(pc_of(3), 1'b1);
        check(pc_of(3), 1'b0, "R6");
        upd(pc_of(3), 1'b0);
        check(pc_of(3), 1'b1, "R6");
    endtask

    task automatic t_alias();
        upd(32'h8000_0013, 1'b0);
        check(pc_of(4), 1'b0, "R7");
        check(32'hFFFF_FFD2, 1'b0, "R7");
        check(pc_of(5), 1'b1, "R7");
        check(pc_of(3), 1'b1, "R7");
    endtask

    task automatic t_idle();
        @(negedge clk);
        upd_valid = 1'b0;
        upd_pc    = pc_of(6);
        upd_taken = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(pc_of(6), 1'b1, "R8");
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        upd_valid = 1'b1;
        upd_pc    = pc_of(7);
        upd_taken = 1'b0;
        check(pc_of(7), 1'b1, "R9");
        @(negedge clk);
        upd_valid = 1'b0;
        check(pc_of(7), 1'b0, "R9");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_train();
        t_zero();
        t_sat();
        t_alias();
        t_idle();
        t_same_cycle();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule